// File: doc/BRIEF.md
# B2 Error-Rate Degrade and Fail Monitor

This block sits behind a SONET receive overhead processor. Once per 125 us frame, a one-cycle `frame_tick` arrives together with that frame's count of line BIP (B2) byte errors. From that count stream the block decides when Signal Degrade (SD) and Signal Fail (SF) are declared and when they are cleared.

SF is judged by two detectors that run side by side. The interval detector uses a long window. The burst detector uses a short window of a few frames. Each has its own window length, declare threshold and clear threshold, and the SF status bit is the OR of the two. SD is declared against a programmable threshold and is released by a fixed rule: a 2048-tick window (256 ms) must hold fewer than 8 errors.

Every transition raises a change bit in an interrupt status byte. That byte is cleared by a read. An active-low interrupt pin stays asserted while any enabled bit is set. The remaining bits of the byte are placeholders that external event pulses set.

Top module: `b2_degrade_monitor`

## Requirements
- R1: The burst detector declares when its running window total, including the current frame, is strictly greater than `bur_set_thr`. A total equal to the threshold does not declare.
- R2: The interval detector declares when its running window total is strictly greater than `int_set_thr`.
- R3: A declared detector clears only on the last tick of a window whose total is at most its clear threshold. Status bit 4 is the OR of both detectors, so SF stays set until both have cleared.
- R4: SD is declared (status bit 3) when the running total of the current SD window is strictly greater than `sd_set_thr`.
- R5: SD clears only on the last tick of a 2048-tick window whose total is below 8. A total of exactly 8 keeps SD declared.
- R6: All windows count frame ticks only. They start at reset, and each accumulator restarts at its own window boundary. Status bits 7..5 and 2..0 read 0.
- R7: Every change of SF sets interrupt bit 7, and every change of SD sets interrupt bit 6, on both declare and clear.
- R8: A frame tick with a nonzero error count sets interrupt bit 4.
- R9: `aux_evt` bits 4,3,2,1,0 set interrupt bits 5,3,2,1,0 respectively.
- R10: `rd_int` clears the whole interrupt byte at the next edge. An event in the same cycle as the read stays set.
- R11: `int_n` is low exactly while some bit of `int_status & int_en` is 1.
- R12: After reset, `status` and `int_status` are 0 and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| b2_err_cnt | input | ERR_W | B2 errors of the frame, valid with `frame_tick` |
| sd_set_thr | input | ACC_W | SD declare threshold |
| int_win_len | input | WIN_W | Interval window length in ticks |
| int_set_thr | input | ACC_W | Interval declare threshold |
| int_clr_thr | input | ACC_W | Interval clear threshold |
| bur_win_len | input | WIN_W | Burst window length in ticks |
| bur_set_thr | input | ACC_W | Burst declare threshold |
| bur_clr_thr | input | ACC_W | Burst clear threshold |
| int_en | input | 8 | Interrupt enable mask |
| aux_evt | input | 5 | External event pulses for placeholder bits |
| rd_int | input | 1 | Read strobe for the interrupt byte |
| status | output | 8 | Defect status byte |
| int_status | output | 8 | Interrupt status byte |
| int_n | output | 1 | Active-low interrupt |

## Verification
A read of the interrupt byte and a new event can land on the same clock edge. The bench provokes this by asserting `rd_int` in the same cycle as a frame tick that carries a nonzero error count. It then expects bit 4 to remain set, with no other bit set and the pin still low, after that edge. The SD clearance boundary is also driven on an exact window edge: 8 errors keep SD declared, and 7 errors release it.

// File: rtl/b2_degrade_monitor.sv
module b2_degrade_monitor #(
  parameter int ERR_W      = 8,
  parameter int ACC_W      = 16,
  parameter int WIN_W      = 16,
  parameter int SD_WIN     = 2048,
  parameter int SD_CLR_LIM = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [ERR_W-1:0] b2_err_cnt,
  input  logic [ACC_W-1:0] sd_set_thr,
  input  logic [WIN_W-1:0] int_win_len,
  input  logic [ACC_W-1:0] int_set_thr,
  input  logic [ACC_W-1:0] int_clr_thr,
  input  logic [WIN_W-1:0] bur_win_len,
  input  logic [ACC_W-1:0] bur_set_thr,
  input  logic [ACC_W-1:0] bur_clr_thr,
  input  logic [7:0]       int_en,
  input  logic [4:0]       aux_evt,
  input  logic             rd_int,
  output logic [7:0]       status,
  output logic [7:0]       int_status,
  output logic             int_n
);

  localparam int SD_CW = $clog2(SD_WIN);
  localparam logic [SD_CW-1:0] SD_LAST = SD_CW'(SD_WIN - 1);
  localparam logic [ACC_W-1:0] SD_LIM  = ACC_W'(SD_CLR_LIM);

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ERR_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W+1)'(b);
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic [SD_CW-1:0] sd_cnt;
  logic [WIN_W-1:0] int_cnt, bur_cnt;
  logic [ACC_W-1:0] sd_acc, int_acc, bur_acc;
  logic [ACC_W-1:0] sd_sum, int_sum, bur_sum;
  logic             sd_q, int_q, bur_q;
  logic             sd_nx, int_nx, bur_nx, sf_q, sf_nx;
  logic             sd_end, int_end, bur_end;
  logic [7:0]       irq, evt;

  assign sd_sum  = sat_add(sd_acc, b2_err_cnt);
  assign int_sum = sat_add(int_acc, b2_err_cnt);
  assign bur_sum = sat_add(bur_acc, b2_err_cnt);

  assign sd_end  = sd_cnt == SD_LAST;
  assign int_end = ({1'b0, int_cnt} + 1'b1) >= {1'b0, int_win_len};
  assign bur_end = ({1'b0, bur_cnt} + 1'b1) >= {1'b0, bur_win_len};

  always_comb begin
    sd_nx  = sd_q;
    int_nx = int_q;
    bur_nx = bur_q;
    if (frame_tick) begin
      if (sd_sum > sd_set_thr)                  sd_nx = 1'b1;
      else if (sd_end && sd_sum < SD_LIM)       sd_nx = 1'b0;
      if (int_sum > int_set_thr)                int_nx = 1'b1;
      else if (int_end && int_sum <= int_clr_thr) int_nx = 1'b0;
      if (bur_sum > bur_set_thr)                bur_nx = 1'b1;
      else if (bur_end && bur_sum <= bur_clr_thr) bur_nx = 1'b0;
    end
  end

  assign sf_q  = int_q | bur_q;
  assign sf_nx = int_nx | bur_nx;

  assign evt = {sf_nx != sf_q, sd_nx != sd_q, aux_evt[4],
                frame_tick && (b2_err_cnt != '0), aux_evt[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_cnt  <= '0;
      int_cnt <= '0;
      bur_cnt <= '0;
      sd_acc  <= '0;
      int_acc <= '0;
      bur_acc <= '0;
      sd_q    <= 1'b0;
      int_q   <= 1'b0;
      bur_q   <= 1'b0;
      irq     <= '0;
    end else begin
      if (frame_tick) begin
        sd_cnt  <= sd_end  ? '0 : sd_cnt + 1'b1;
        sd_acc  <= sd_end  ? '0 : sd_sum;
        int_cnt <= int_end ? '0 : int_cnt + 1'b1;
        int_acc <= int_end ? '0 : int_sum;
        bur_cnt <= bur_end ? '0 : bur_cnt + 1'b1;
        bur_acc <= bur_end ? '0 : bur_sum;
      end
      sd_q  <= sd_nx;
      int_q <= int_nx;
      bur_q <= bur_nx;
      irq   <= (rd_int ? 8'h00 : irq) | evt;
    end
  end

  assign status     = {3'b000, sf_q, sd_q, 3'b000};
  assign int_status = irq;
  assign int_n      = ~|(irq & int_en);

  a_r5_sd_clear_on_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_q) |-> $past(frame_tick && sd_end));

  a_r3_sf_clear_on_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sf_q) |-> $past(frame_tick && (int_end || bur_end)));

  a_r7_sf_change_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_q != $past(sf_q)) |-> irq[7]);

  a_r7_sd_change_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_q != $past(sd_q)) |-> irq[6]);

  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && b2_err_cnt != '0) |=> irq[4]);

  // R11: pin released once a quiet read has emptied the byte
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && !frame_tick && aux_evt == '0) |=> (irq == '0 && int_n));

endmodule

// File: tb/b2_degrade_monitor_bench.sv
module b2_degrade_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 16;

  // row = {err[7:0], ticks[15:0], status[7:0], change bits[7:0]}
  localparam logic [39:0] VEC [NROWS] = '{
    {8'd0,  16'd8,    8'h00, 8'h00},
    {8'd3,  16'd8,    8'h10, 8'h80},
    {8'd0,  16'd8,    8'h00, 8'h80},
    {8'd2,  16'd40,   8'h08, 8'h40},
    {8'd4,  16'd64,   8'h18, 8'h80},
    {8'd1,  16'd8,    8'h18, 8'h00},
    {8'd0,  16'd8,    8'h18, 8'h00},
    {8'd0,  16'd48,   8'h08, 8'h80},
    {8'd0,  16'd1856, 8'h08, 8'h00},
    {8'd1,  16'd8,    8'h08, 8'h00},
    {8'd0,  16'd2040, 8'h08, 8'h00},
    {8'd1,  16'd7,    8'h08, 8'h00},
    {8'd0,  16'd2041, 8'h00, 8'h40},
    {8'd20, 16'd1,    8'h00, 8'h00},
    {8'd1,  16'd1,    8'h10, 8'h80},
    {8'd0,  16'd15,   8'h00, 8'h80}
  };
  localparam string VREQ [NROWS] = '{"R6", "R1", "R3", "R4", "R2", "R3", "R3", "R3",
                                     "R5", "R5", "R5", "R5", "R5", "R1", "R1", "R3"};

  logic clk = 0, rst_n = 0, frame_tick = 0, rd_int = 0;
  logic [7:0] b2_err_cnt = 0, int_en = 8'hFF;
  logic [4:0] aux_evt = 0;
  logic [7:0] status, int_status;
  logic int_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b2_degrade_monitor u_b2_degrade_monitor (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .b2_err_cnt(b2_err_cnt),
    .sd_set_thr(16'd50),
    .int_win_len(16'd64), .int_set_thr(16'd200), .int_clr_thr(16'd10),
    .bur_win_len(16'd8),  .bur_set_thr(16'd20),  .bur_clr_thr(16'd4),
    .int_en(int_en), .aux_evt(aux_evt), .rd_int(rd_int),
    .status(status), .int_status(int_status), .int_n(int_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input logic [7:0] e, input int n);
    frame_tick = 1; b2_err_cnt = e;
    for (int i = 0; i < n; i++) @(negedge clk);
    frame_tick = 0; b2_err_cnt = 0;
  endtask

  task automatic do_read();
    rd_int = 1; @(negedge clk); rd_int = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 status", status, 8'h00);
    check("R12 int_status", int_status, 8'h00);
    check("R12 int_n", int_n, 1'b1);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      ticks(VEC[r][39:32], int'(VEC[r][31:16]));
      check({VREQ[r], " status"}, status, VEC[r][15:8]);
      check("R7 change bits", int_status & 8'hC0, VEC[r][7:0]);
      do_read();
    end

    // R8 and R11: error tick flags bit 4 and pulls the pin
    ticks(8'd1, 1);
    check("R8 err bit", int_status, 8'h10);
    check("R11 pin low", int_n, 1'b0);
    do_read();
    check("R10 read clears", int_status, 8'h00);
    check("R11 pin released", int_n, 1'b1);

    // R11: masked bit keeps pin high
    int_en = 8'hEF;
    ticks(8'd1, 1);
    check("R11 masked bit set", int_status, 8'h10);
    check("R11 masked pin high", int_n, 1'b1);
    int_en = 8'hFF;
    #1;
    check("R11 unmasked pin low", int_n, 1'b0);
    do_read();

    // R10: event coincides with read, event wins
    rd_int = 1; frame_tick = 1; b2_err_cnt = 8'd2;
    @(negedge clk);
    rd_int = 0; frame_tick = 0; b2_err_cnt = 0;
    check("R10 event wins over read", int_status, 8'h10);
    check("R10 pin held", int_n, 1'b0);
    do_read();

    // R9: placeholder events
    aux_evt = 5'b10001; @(negedge clk); aux_evt = 0;
    check("R9 aux bits 5 and 0", int_status, 8'h21);
    do_read();
    aux_evt = 5'b01110; @(negedge clk); aux_evt = 0;
    check("R9 aux bits 3..1", int_status, 8'h0E);
    do_read();
    check("R6 status others zero", status, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule